// File: doc/BRIEF.md
# Paged Serial EEPROM Slave Controller

This block is the device side of a 256-byte serial EEPROM behind a four-wire SPI link in clock mode 0. The memory is split into 16 pages of 16 bytes. The block samples the pins with the system clock and finds the select and serial-clock edges itself. It decodes six one-byte instructions: set the write latch, clear the write latch, read status, write status, read memory and write memory.

Writes to memory and to the status byte are guarded in three ways. The write latch must be set beforehand in a select cycle of its own. The write-protect pin must be inactive. The target page must lie outside the region that the two protect bits cover. An accepted write commits when select is released. It then runs a self-timed programming interval, and the in-progress status bit stays high for the whole interval. A hold pin freezes a transfer in mid-byte so that the host can use the bus for other traffic.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, the write latch is clear and no programming interval is running. The two protect bits keep the value they held before the reset.
- R2: Input bits are taken MSB first on rising serial-clock edges. Output bits change only after falling edges. `miso_oe` is high only while status or memory bytes are being shifted out, and it is low whenever the device is deselected.
- R3: Opcode 0x06 sets the write latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte: bit 0 is write-in-progress, bit 1 is the write latch, bits 3:2 are the protect bits and bits 7:4 are zero. After that byte, `miso_oe` stays low until deselect. Unknown opcodes change nothing.
- R4: Opcode 0x03 followed by an address byte streams out bytes from consecutive addresses. The address wraps from 0xFF to 0x00.
- R5: Opcode 0x02, an address byte and one or more data bytes form a memory write. It commits only if the write latch was set. Committing clears the latch. Without the latch, memory is unchanged.
- R6: During a memory write, data bytes that run past the end of the 16-byte page wrap to offset 0 of the same page.
- R7: Opcode 0x01 followed by a data byte copies bits 3:2 of that byte into the protect bits. The same latch and commit rules as a memory write apply.
- R8: The protect bits lock part of the array: 00 locks nothing, 01 locks addresses 0xC0 and up, 10 locks 0x80 and up, 11 locks everything. A write to a locked page leaves memory and the write latch unchanged.
- R9: While `wp_n` is low, no memory write and no status write commits, and the write latch is left unchanged.
- R10: A commit starts a programming interval of PROG_CYCLES clocks with write-in-progress set. During the interval only opcode 0x05 is decoded, and every other opcode is ignored.
- R11: Pulling `hold_n` low while the serial clock is low pauses the transfer. Serial-clock edges are then ignored and `miso_oe` is low. Releasing `hold_n` with the clock low resumes the transfer at the same bit.
- R12: If select rises while the transfer is held, nothing commits. The next select starts a fresh instruction.
- R13: If select rises anywhere other than a byte boundary, the pending write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | High while `miso` should drive the line |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| wp_n | input | 1 | Active-low write protect |

## Verification
The bench keeps the default geometry of 16 pages of 16 bytes. This places the page-wrap seam and the quarter and half protection boundaries at the real addresses 0x1F/0x10, 0xC0 and 0x80. It shortens PROG_CYCLES to 1000. That interval is long enough for two complete status reads and an ignored latch-set opcode to fall inside one programming interval, and short enough to let the run commit several writes. The serial clock runs at one sixteenth of the system clock, so each pin passes through its synchronizer well inside half a bit.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_WSR,
        PH_RSR,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              WIDTH     = 5,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign pipe_d[s] = pin_i;
        end else begin : g_next
            assign pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/eeprom_protect.sv
module eeprom_protect #(
    parameter int PAGE_W = 4
) (
    input  logic [1:0]        bp_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              locked_o
);
    always_comb begin
        case (bp_i)
            2'd0:    locked_o = 1'b0;
            2'd1:    locked_o = &page_i[PAGE_W-1:PAGE_W-2];
            2'd2:    locked_o = page_i[PAGE_W-1];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import spi_eeprom_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int NUM_PAGES   = 16,
    parameter int PROG_CYCLES = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe,
    input  logic hold_n,
    input  logic wp_n
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = $clog2(NUM_PAGES);
    localparam int ADDR_W = OFS_W + PAGE_W;
    localparam int DEPTH  = PAGE_BYTES * NUM_PAGES;

    typedef struct packed {
        phase_e                       phase;
        logic [2:0]                   bitc;
        logic [7:0]                   rx;
        logic [7:0]                   tx;
        logic                         out_bit;
        logic [ADDR_W-1:0]            addr;
        logic [PAGE_BYTES-1:0][7:0]   pbuf;
        logic [PAGE_BYTES-1:0]        pvld;
        logic [1:0]                   sr_bp;
        logic                         have_data;
        logic                         wel;
        logic                         held;
        logic                         is_rd;
        logic                         cs_p;
        logic                         sck_p;
    } ctl_t;

    // synchronised pins: [0] select, [1] clock, [2] data, [3] hold, [4] protect
    logic [4:0] pins_s;
    logic       cs_s, sck_s, mosi_s, hold_s, wp_s;

    spi_pin_sync #(
        .WIDTH    (5),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(5'b11001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({wp_n, hold_n, mosi, sck, cs_n}),
        .sync_o(pins_s)
    );

    assign {wp_s, hold_s, mosi_s, sck_s, cs_s} = pins_s;

    ctl_t       ctl_d, ctl_q;
    logic [1:0] bp_d;
    logic [1:0] bp_q = 2'b00;
    logic [7:0] mem_q [DEPTH] = '{default: 8'h00};
    logic       commit_mem, commit_sr, busy, page_locked;
    logic       cs_rise, cs_fall, sck_rise, sck_fall;
    logic [7:0] rx_byte, status_byte;

    eeprom_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(commit_mem | commit_sr),
        .busy_o (busy)
    );

    eeprom_protect #(.PAGE_W(PAGE_W)) u_protect (
        .bp_i    (bp_q),
        .page_i  (ctl_q.addr[ADDR_W-1:OFS_W]),
        .locked_o(page_locked)
    );

    assign cs_rise     = cs_s & ~ctl_q.cs_p;
    assign cs_fall     = ~cs_s & ctl_q.cs_p;
    assign sck_rise    = sck_s & ~ctl_q.sck_p;
    assign sck_fall    = ~sck_s & ctl_q.sck_p;
    assign rx_byte     = {ctl_q.rx[6:0], mosi_s};
    assign status_byte = {4'b0000, bp_q, ctl_q.wel, busy};

    always_comb begin
        ctl_d       = ctl_q;
        commit_mem  = 1'b0;
        commit_sr   = 1'b0;
        ctl_d.cs_p  = cs_s;
        ctl_d.sck_p = sck_s;
        if (cs_s) begin
            // end of select: commit only on a clean byte boundary outside hold
            if (cs_rise && !ctl_q.held && ctl_q.have_data && (ctl_q.bitc == 3'd0)
                && ctl_q.wel && wp_s && !busy) begin
                commit_mem = (ctl_q.phase == PH_WDATA) && !page_locked;
                commit_sr  = (ctl_q.phase == PH_WSR);
            end
            if (commit_mem || commit_sr) ctl_d.wel = 1'b0;
            ctl_d.phase     = PH_IDLE;
            ctl_d.held      = 1'b0;
            ctl_d.have_data = 1'b0;
            ctl_d.bitc      = 3'd0;
        end else if (cs_fall) begin
            ctl_d.phase     = PH_CMD;
            ctl_d.bitc      = 3'd0;
            ctl_d.held      = 1'b0;
            ctl_d.have_data = 1'b0;
        end else begin
            if (!sck_s) ctl_d.held = !hold_s;
            if (!ctl_q.held && sck_rise && (ctl_q.phase != PH_IDLE)) begin
                ctl_d.rx   = rx_byte;
                ctl_d.bitc = ctl_q.bitc + 3'd1;
                if (ctl_q.bitc == 3'd7) begin
                    case (ctl_q.phase)
                        PH_CMD: begin
                            if (busy && (rx_byte != OP_STAT_RD)) begin
                                ctl_d.phase = PH_DONE;
                            end else begin
                                case (rx_byte)
                                    OP_WEN_SET: begin ctl_d.wel = 1'b1; ctl_d.phase = PH_DONE; end
                                    OP_WEN_CLR: begin ctl_d.wel = 1'b0; ctl_d.phase = PH_DONE; end
                                    OP_STAT_RD: begin ctl_d.tx = status_byte; ctl_d.phase = PH_RSR; end
                                    OP_STAT_WR: ctl_d.phase = PH_WSR;
                                    OP_MEM_RD:  begin ctl_d.is_rd = 1'b1; ctl_d.phase = PH_ADDR; end
                                    OP_MEM_WR:  begin ctl_d.is_rd = 1'b0; ctl_d.phase = PH_ADDR; end
                                    default:    ctl_d.phase = PH_DONE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (ctl_q.is_rd) begin
                                ctl_d.tx    = mem_q[rx_byte[ADDR_W-1:0]];
                                ctl_d.addr  = rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                                ctl_d.phase = PH_RDATA;
                            end else begin
                                ctl_d.addr  = rx_byte[ADDR_W-1:0];
                                ctl_d.pvld  = '0;
                                ctl_d.phase = PH_WDATA;
                            end
                        end
                        PH_WDATA: begin
                            ctl_d.pbuf[ctl_q.addr[OFS_W-1:0]] = rx_byte;
                            ctl_d.pvld[ctl_q.addr[OFS_W-1:0]] = 1'b1;
                            ctl_d.addr = {ctl_q.addr[ADDR_W-1:OFS_W],
                                          ctl_q.addr[OFS_W-1:0] + OFS_W'(1)};
                            ctl_d.have_data = 1'b1;
                        end
                        PH_RDATA: begin
                            ctl_d.tx   = mem_q[ctl_q.addr];
                            ctl_d.addr = ctl_q.addr + ADDR_W'(1);
                        end
                        PH_WSR: begin
                            ctl_d.sr_bp     = rx_byte[3:2];
                            ctl_d.have_data = 1'b1;
                        end
                        PH_RSR:  ctl_d.phase = PH_DONE;
                        default: ;
                    endcase
                end
            end else if (!ctl_q.held && sck_fall) begin
                ctl_d.out_bit = ctl_q.tx[3'd7 - ctl_q.bitc];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // protect bits are retained across reset
    always_comb bp_d = commit_sr ? ctl_q.sr_bp : bp_q;

    always_ff @(posedge clk) begin
        bp_q <= bp_d;
    end

    always_ff @(posedge clk) begin
        if (commit_mem) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (ctl_q.pvld[i]) mem_q[{ctl_q.addr[ADDR_W-1:OFS_W], OFS_W'(i)}] <= ctl_q.pbuf[i];
            end
        end
    end

    assign miso_oe = ((ctl_q.phase == PH_RDATA) || (ctl_q.phase == PH_RSR))
                     && !ctl_q.held && !cs_s;
    assign miso    = miso_oe & ctl_q.out_bit;
endmodule

// File: rtl/spi_eeprom_checker.sv
module spi_eeprom_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       miso_oe,
    input logic       cs_s,
    input logic       held,
    input logic       wel,
    input logic       busy,
    input logic       commit_mem,
    input logic       commit_sr,
    input logic [1:0] bp
);
    p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !miso_oe);

    p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !miso_oe);

    p_commit_clears_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_mem || commit_sr) |=> !wel);

    p_commit_starts_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_mem || commit_sr) |=> busy);

    p_no_commit_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(commit_mem || commit_sr));

    p_bp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_sr |=> $stable(bp));
endmodule

bind spi_eeprom_slave spi_eeprom_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .miso_oe   (miso_oe),
    .cs_s      (cs_s),
    .held      (ctl_q.held),
    .wel       (ctl_q.wel),
    .busy      (busy),
    .commit_mem(commit_mem),
    .commit_sr (commit_sr),
    .bp        (bp_q)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
    import spi_eeprom_pkg::*;

    localparam int PROG = 1000;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic miso, miso_oe;

    always #10 clk = ~clk;

    spi_eeprom_slave #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .hold_n(hold_n), .wp_n(wp_n)
    );

    int   n_chk = 0, n_fail = 0;
    bit   quiet_mon = 0, done = 0;
    logic [7:0] mem_m [256];
    bit   wel_m = 0, busy_m = 0;
    logic [1:0] bp_m = 2'b00;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R2: output enable must stay low while deselected
    always @(negedge clk) if (quiet_mon && !done) check("R2 deselected", int'(miso_oe), 0);

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r, output logic oe);
        mosi = b; wait_clk(HALF);
        r = miso; oe = miso_oe;
        sck = 1'b1; wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
        logic r, oe;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(tx[i], r, oe);
            rx[i] = r;
            oe_all = oe_all & oe;
        end
    endtask

    task automatic cs_on();
        quiet_mon = 0; cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic cs_off();
        wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF); quiet_mon = 1;
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [7:0] r; logic o;
        cs_on(); xbyte(op, r, o); cs_off();
    endtask

    task automatic status_chk(input string req);
        logic [7:0] r, s; logic o, so;
        cs_on(); xbyte(OP_STAT_RD, r, o); xbyte(8'h00, s, so); cs_off();
        check(req, int'(s), int'({4'b0000, bp_m, wel_m, busy_m}));
        check(req, int'(so), 1);
    endtask

    function automatic bit locked_m(input logic [7:0] a);
        case (bp_m)
            2'd0:    return 1'b0;
            2'd1:    return a >= 8'hC0;
            2'd2:    return a >= 8'h80;
            default: return 1'b1;
        endcase
    endfunction

    task automatic mem_write(input logic [7:0] a, input logic [7:0] q[$], input int extra);
        logic [7:0] r; logic o, rb;
        cs_on(); xbyte(OP_MEM_WR, r, o); xbyte(a, r, o);
        foreach (q[i]) xbyte(q[i], r, o);
        for (int i = 0; i < extra; i++) xbit(1'b1, rb, o);
        cs_off();
        if (extra == 0 && q.size() > 0 && wel_m && wp_n && !busy_m && !locked_m(a)) begin
            foreach (q[i]) mem_m[{a[7:4], 4'(int'(a[3:0]) + i)}] = q[i];
            wel_m = 0; busy_m = 1;
        end
    endtask

    task automatic stat_write(input logic [7:0] v);
        logic [7:0] r; logic o;
        cs_on(); xbyte(OP_STAT_WR, r, o); xbyte(v, r, o); cs_off();
        if (wel_m && wp_n && !busy_m) begin
            bp_m = v[3:2]; wel_m = 0; busy_m = 1;
        end
    endtask

    task automatic settle();
        wait_clk(PROG + 20); busy_m = 0;
    endtask

    task automatic read_chk(input logic [7:0] a, input int n, input string req);
        logic [7:0] r; logic o;
        cs_on(); xbyte(OP_MEM_RD, r, o); xbyte(a, r, o);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, o);
            check(req, int'(r), int'(mem_m[8'(int'(a) + i)]));
            check(req, int'(o), 1);
        end
        cs_off();
    endtask

    task automatic hold_pause(input string req);
        hold_n = 1'b0; wait_clk(HALF);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; wait_clk(HALF);
            check(req, int'(miso_oe), 0);
            sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1; wait_clk(HALF);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [7:0] q[$];
        logic [7:0] r, s, v;
        logic o, rb;
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        wait_clk(5); rst_n = 1'b1; wait_clk(5); quiet_mon = 1;

        // R1 reset state
        check("R1 oe after reset", int'(miso_oe), 0);
        status_chk("R1 status after reset");

        // R5 write without latch does nothing
        q = {8'hAA};
        mem_write(8'h05, q, 0);
        read_chk(8'h05, 1, "R5 no latch");

        // R3 latch set/clear, unknown opcode
        op_only(OP_WEN_SET); wel_m = 1; status_chk("R3 latch set");
        op_only(OP_WEN_CLR); wel_m = 0; status_chk("R3 latch clear");
        op_only(8'hFF); status_chk("R3 unknown opcode");

        // R3 output goes quiet after the status byte
        cs_on(); xbyte(OP_STAT_RD, r, o); xbyte(8'h00, s, o);
        check("R3 status oe", int'(o), 1);
        xbyte(8'h00, s, o);
        check("R3 quiet after status", int'(o), 0);
        cs_off();

        // R6 page wrap, R10 busy and ignore
        op_only(OP_WEN_SET); wel_m = 1;
        q = {8'hA1, 8'hA2, 8'hA3, 8'hA4};
        mem_write(8'h1E, q, 0);
        status_chk("R10 busy after commit");
        op_only(OP_WEN_SET);
        status_chk("R10 opcode ignored while busy");
        settle();
        status_chk("R10 idle after interval");
        read_chk(8'h10, 16, "R6 page wrap");

        // R4 read address wrap
        op_only(OP_WEN_SET); wel_m = 1;
        q = {8'hC1, 8'hC2, 8'hC3};
        mem_write(8'hFE, q, 0);
        settle();
        read_chk(8'hFE, 3, "R4 read wrap");
        read_chk(8'hF0, 1, "R6 wrap at top page");

        // R13 select rise mid-byte
        op_only(OP_WEN_SET); wel_m = 1;
        q = {8'h77};
        mem_write(8'h40, q, 3);
        status_chk("R13 latch kept");
        read_chk(8'h40, 1, "R13 no commit");

        // R7 status write to protect upper quarter
        stat_write(8'h04);
        status_chk("R7 busy");
        settle();
        status_chk("R7 protect bits");

        // R8 locked page
        op_only(OP_WEN_SET); wel_m = 1;
        q = {8'h11};
        mem_write(8'hC5, q, 0);
        status_chk("R8 blocked keeps latch");
        q = {8'h22};
        mem_write(8'h85, q, 0);
        settle();
        read_chk(8'hC5, 1, "R8 locked unchanged");
        read_chk(8'h85, 1, "R8 unlocked written");

        // R9 write-protect pin
        wp_n = 1'b0;
        op_only(OP_WEN_SET); wel_m = 1;
        q = {8'h33};
        mem_write(8'h20, q, 0);
        stat_write(8'h00);
        status_chk("R9 protect pin");
        read_chk(8'h20, 1, "R9 memory unchanged");
        wp_n = 1'b1;

        // R11 hold in the middle of a read byte
        cs_on(); xbyte(OP_MEM_RD, r, o); xbyte(8'h10, r, o);
        xbyte(8'h00, r, o);
        check("R11 first byte", int'(r), int'(mem_m[8'h10]));
        for (int i = 7; i >= 4; i--) begin xbit(1'b0, rb, o); v[i] = rb; end
        hold_pause("R11 held quiet");
        for (int i = 3; i >= 0; i--) begin xbit(1'b0, rb, o); v[i] = rb; end
        check("R11 resumed byte", int'(v), int'(mem_m[8'h11]));
        cs_off();

        // R12 deselect while held
        cs_on(); xbyte(OP_MEM_WR, r, o); xbyte(8'h30, r, o); xbyte(8'h5A, r, o);
        hold_n = 1'b0; wait_clk(HALF);
        cs_n = 1'b1; wait_clk(HALF);
        hold_n = 1'b1; wait_clk(2 * HALF); quiet_mon = 1;
        status_chk("R12 fresh select no commit");
        read_chk(8'h30, 1, "R12 memory unchanged");

        // R1 reset keeps protect bits, clears latch
        rst_n = 1'b0; wait_clk(4); rst_n = 1'b1; wait_clk(4);
        wel_m = 0;
        check("R1 oe after second reset", int'(miso_oe), 0);
        status_chk("R1 protect retained");

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule